// File: doc/BRIEF.md
# Configuration Stream Header Validator

This block sits in front of a configuration loader and watches a stream of 32-bit words qualified by a valid strobe. It inspects the leading 21 words of a bitstream header: sixteen fill words, two bus-width marker words, two more fill words and a final sync word. The sync word in the last position decides whether the stream arrived in native byte order or with the four bytes of every word reversed. The block then judges the whole header under that one order.

The verdict is registered and held until the next start pulse. It gives four flags: a done flag, a pass flag, a swapped-order flag and a short-stream flag for a stream that ended before the header was complete. Words and end markers that arrive after the verdict are ignored. A start pulse clears the verdict and rearms the block for a new stream.

Top module: `cfg_hdr_validator`

## Requirements
- R1: After a synchronous active-low reset, `done`, `hdr_ok`, `swapped` and `short_err` are all 0.
- R2: A header in native order is accepted. Position 20 is 0xAA995566, positions 16 and 17 are 0x000000BB and 0x11220044, and every other position is 0xFFFFFFFF. The cycle after word 20 is accepted, the outputs show done=1, hdr_ok=1, swapped=0 and short_err=0.
- R3: A header in which every word has its bytes reversed (byte 0 swapped with byte 3, byte 1 with byte 2) is accepted with swapped=1. Position 20 then reads 0x665599AA.
- R4: The order is taken from position 20 alone. Any word that does not match its pattern under that order gives done=1, hdr_ok=0, with swapped still reporting the order taken from position 20.
- R5: If position 20 is neither 0xAA995566 nor 0x665599AA, the verdict is done=1, hdr_ok=0, swapped=0, short_err=0.
- R6: If `stream_end` is seen before 21 words have been accepted, the verdict is done=1, short_err=1, hdr_ok=0, swapped=0. A `stream_end` that arrives together with word 20 counts the header as complete.
- R7: Once done=1, further words and `stream_end` have no effect, and all four outputs hold until `start`.
- R8: `start` clears all outputs and the word position in the following cycle. A word presented in the same cycle as `start` is discarded.
- R9: Only cycles with `word_vld`=1 advance the header position, so idle gaps between words do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the verdict and restarts at position 0 |
| word_vld | input | 1 | Qualifies `word_data` |
| word_data | input | 32 | Incoming stream word |
| stream_end | input | 1 | Marks that the stream has ended |
| done | output | 1 | Verdict available |
| hdr_ok | output | 1 | Header matched under the detected order |
| swapped | output | 1 | Sync word was found byte-reversed |
| short_err | output | 1 | Stream ended before the header was complete |

## Verification
The header is tried in native order and in fully byte-reversed order, both with and without idle gaps. This separates correct order detection from position counting that miscounts on gaps. Corrupted headers are also sent: a marker word corrupted, a single native-order word inside a reversed header, and native words closed by a reversed sync word. These show that the order comes from the sync position alone and is then applied to every position. Streams ended after zero and ten words, and a stream_end arriving with the sync word, test the boundary of the short-stream rule. A start pulse with a word in the same cycle, and another in the middle of a header, test the discard and restart behaviour.

// File: rtl/cfg_hdr_pkg.sv
// Package: constants and helpers shared by the header validator.
// Assumes a 32-bit word split into four bytes.
package cfg_hdr_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned HDR_WORDS   = 21;
    localparam int unsigned MARK_A_POS  = 16;
    localparam int unsigned MARK_B_POS  = 17;
    localparam logic [WORD_W-1:0] FILL_VAL   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] MARK_A_VAL = 32'h0000_00BB;
    localparam logic [WORD_W-1:0] MARK_B_VAL = 32'h1122_0044;
    localparam logic [WORD_W-1:0] SYNC_VAL   = 32'hAA99_5566;
    localparam int unsigned N_ORDERS    = 2;  // index 0 native, 1 byte-reversed

    // Reverse the byte order of one word.
    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[(WORD_W/8-1-b)*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/cfg_hdr_pos_counter.sv
// Module: tracks the header position of the next accepted word.
// Assumes clr has priority over adv; holds at the last position.
module cfg_hdr_pos_counter #(
    parameter int unsigned HDR_LEN = 21,
    localparam int unsigned IDX_W  = $clog2(HDR_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] pos,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(HDR_LEN - 1);

    logic [IDX_W-1:0] pos_q;

    // Position register: cleared by reset or clr, advanced per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q <= '0;
        end else if (adv && pos_q != LAST_POS) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Flags the position that carries the sync word.
    always_comb begin
        at_last = (pos_q == LAST_POS);
    end

    assign pos = pos_q;
endmodule

// File: rtl/cfg_hdr_word_cmp.sv
// Module: compares one word against the expected pattern for its position,
// once as received and once byte-reversed. Purely combinational.
module cfg_hdr_word_cmp
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned HDR_LEN = 21,
    parameter int unsigned MARK_A  = 16,
    parameter int unsigned MARK_B  = 17,
    localparam int unsigned IDX_W  = $clog2(HDR_LEN + 1)
) (
    input  logic [WORD_W-1:0]   word,
    input  logic [IDX_W-1:0]    pos,
    output logic [N_ORDERS-1:0] match
);
    logic [WORD_W-1:0] expect_w;

    // Expected pattern for the current header position.
    always_comb begin
        if (pos == IDX_W'(HDR_LEN - 1)) begin
            expect_w = SYNC_VAL;
        end else if (pos == IDX_W'(MARK_A)) begin
            expect_w = MARK_A_VAL;
        end else if (pos == IDX_W'(MARK_B)) begin
            expect_w = MARK_B_VAL;
        end else begin
            expect_w = FILL_VAL;
        end
    end

    for (genvar o = 0; o < N_ORDERS; o++) begin : g_order
        logic [WORD_W-1:0] view;
        // View of the word under this byte order, then its comparison.
        always_comb begin
            view     = (o == 1) ? byte_rev(word) : word;
            match[o] = (view == expect_w);
        end
    end
endmodule

// File: rtl/cfg_hdr_verdict.sv
// Module: keeps one running pass flag per byte order and registers the verdict.
// Assumes match[1:0] reports the sync compare when at_last is high.
module cfg_hdr_verdict
    import cfg_hdr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                adv,
    input  logic                at_last,
    input  logic [N_ORDERS-1:0] match,
    input  logic                stream_end,
    output logic                done,
    output logic                hdr_ok,
    output logic                swapped,
    output logic                short_err
);
    logic [N_ORDERS-1:0] pass_q;
    logic [N_ORDERS-1:0] pass_now;
    logic                done_q, ok_q, swp_q, short_q;
    logic                finish;

    // Pass flags including the word being accepted; final-word detection.
    always_comb begin
        pass_now = pass_q & match;
        finish   = adv && at_last;
    end

    // Per-order pass flags: set on clear, cleared by any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pass_q <= '1;
        end else if (adv) begin
            pass_q <= pass_now;
        end
    end

    // Verdict register: written once per stream, held until clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            swp_q   <= 1'b0;
            short_q <= 1'b0;
        end else if (!done_q) begin
            if (finish) begin
                done_q  <= 1'b1;
                ok_q    <= |pass_now;
                swp_q   <= match[1];
                short_q <= 1'b0;
            end else if (stream_end) begin
                done_q  <= 1'b1;
                ok_q    <= 1'b0;
                swp_q   <= 1'b0;
                short_q <= 1'b1;
            end
        end
    end

    assign done      = done_q;
    assign hdr_ok    = ok_q;
    assign swapped   = swp_q;
    assign short_err = short_q;
endmodule

// File: rtl/cfg_hdr_validator.sv
// Module: top of the header validator. Accepts words until a verdict exists;
// start clears and discards any word of the same cycle.
module cfg_hdr_validator
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned HDR_LEN = cfg_hdr_pkg::HDR_WORDS,
    parameter int unsigned MARK_A  = cfg_hdr_pkg::MARK_A_POS,
    parameter int unsigned MARK_B  = cfg_hdr_pkg::MARK_B_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              stream_end,
    output logic              done,
    output logic              hdr_ok,
    output logic              swapped,
    output logic              short_err
);
    localparam int unsigned IDX_W = $clog2(HDR_LEN + 1);

    logic [IDX_W-1:0]    pos;
    logic                at_last;
    logic                accept;
    logic [N_ORDERS-1:0] match;

    // A word counts only while no verdict is held and no start is present.
    always_comb begin
        accept = word_vld && !done && !start;
    end

    cfg_hdr_pos_counter #(.HDR_LEN(HDR_LEN)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .adv     (accept),
        .pos     (pos),
        .at_last (at_last)
    );

    cfg_hdr_word_cmp #(.HDR_LEN(HDR_LEN), .MARK_A(MARK_A), .MARK_B(MARK_B)) u_cmp (
        .word  (word_data),
        .pos   (pos),
        .match (match)
    );

    cfg_hdr_verdict u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .adv        (accept),
        .at_last    (at_last),
        .match      (match),
        .stream_end (stream_end),
        .done       (done),
        .hdr_ok     (hdr_ok),
        .swapped    (swapped),
        .short_err  (short_err)
    );
endmodule

// File: rtl/cfg_hdr_validator_chk.sv
// Checker: temporal properties of the validator ports, bound to the top.
module cfg_hdr_validator_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic word_vld,
    input logic stream_end,
    input logic done,
    input logic hdr_ok,
    input logic swapped,
    input logic short_err
);
    // R8: start clears every output in the next cycle.
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !hdr_ok && !swapped && !short_err));

    // R7: a held verdict stays unchanged until start.
    p_verdict_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(hdr_ok) && $stable(swapped) && $stable(short_err)));

    // R6: a short stream never reports a pass or an order.
    p_short_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> (done && !hdr_ok && !swapped));

    // R2: pass or order flags only appear together with done.
    p_flags_need_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_ok || swapped) |-> done);

    // R9: without a word or an end marker, no verdict appears.
    p_idle_no_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !word_vld && !stream_end) |=> !done);
endmodule

bind cfg_hdr_validator cfg_hdr_validator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_vld   (word_vld),
    .stream_end (stream_end),
    .done       (done),
    .hdr_ok     (hdr_ok),
    .swapped    (swapped),
    .short_err  (short_err)
);

// File: tb/cfg_hdr_validator_tb_top.sv
// Bench: behavioural queue-based reference model, compared on every clock,
// plus explicit verdict checks per scenario.
module cfg_hdr_validator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SYNC = 32'hAA995566;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] word_data = '0;
    logic        stream_end = 1'b0;
    logic        done, hdr_ok, swapped, short_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    armed = 1'b0;
    string cur_req = "R1";

    logic [31:0] q[$];
    bit m_done, m_ok, m_sw, m_sh;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_validator dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .word_vld(word_vld),
        .word_data(word_data), .stream_end(stream_end), .done(done),
        .hdr_ok(hdr_ok), .swapped(swapped), .short_err(short_err)
    );

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pattern(input int i);
        if (i == 16) return 32'h000000BB;
        if (i == 17) return 32'h11220044;
        if (i == 20) return SYNC;
        return 32'hFFFFFFFF;
    endfunction

    // Reference model, evaluated once per clock with the driven inputs.
    task automatic model_update(input bit r, input bit st, input bit v,
                                input logic [31:0] d, input bit e);
        bit rev;
        if (!r || st) begin
            q.delete();
            {m_done, m_ok, m_sw, m_sh} = 4'b0000;
        end else if (!m_done) begin
            if (v) q.push_back(d);
            if (q.size() == 21) begin
                m_done = 1'b1;
                m_sh = 1'b0;
                if (q[20] == SYNC || bswap(q[20]) == SYNC) begin
                    rev = (q[20] != SYNC);
                    m_sw = rev;
                    m_ok = 1'b1;
                    foreach (q[i]) if ((rev ? bswap(q[i]) : q[i]) != pattern(i)) m_ok = 1'b0;
                end else begin
                    m_ok = 1'b0;
                    m_sw = 1'b0;
                end
            end else if (e) begin
                {m_done, m_ok, m_sw, m_sh} = 4'b1001;
            end
        end
    endtask

    task automatic compare_now();
        if (!armed) return;
        n_cmp++;
        if ({done, hdr_ok, swapped, short_err} !== {m_done, m_ok, m_sw, m_sh}) begin
            n_bad++;
            $display("FAIL %s model compare at %0t: actual done/ok/sw/short=%b%b%b%b expected %b%b%b%b",
                     cur_req, $time, done, hdr_ok, swapped, short_err, m_done, m_ok, m_sw, m_sh);
        end
    endtask

    task automatic step(input bit r, input bit st, input bit v,
                        input logic [31:0] d, input bit e);
        @(negedge clk);
        compare_now();
        rst_n = r; start = st; word_vld = v; word_data = d; stream_end = e;
        @(posedge clk);
        model_update(r, st, v, d, e);
        #1;
        start = 1'b0; word_vld = 1'b0; stream_end = 1'b0;
    endtask

    task automatic expect_out(input string tag, input bit d, input bit o,
                              input bit s, input bit sh);
        @(negedge clk);
        n_cmp++;
        if ({done, hdr_ok, swapped, short_err} !== {d, o, s, sh}) begin
            n_bad++;
            $display("FAIL %s verdict: actual done/ok/sw/short=%b%b%b%b expected %b%b%b%b",
                     tag, done, hdr_ok, swapped, short_err, d, o, s, sh);
        end
    endtask

    // Sends n header words; optional reversal, corruption, gaps, end marker on last.
    task automatic send_words(input bit rev, input int n, input int bad_i,
                              input logic [31:0] bad_v, input bit gaps, input bit end_last);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = pattern(i);
            if (rev) w = bswap(w);
            if (i == bad_i) w = bad_v;
            if (gaps && (i % 3 == 1)) step(1, 0, 0, 32'h0, 0);
            step(1, 0, 1, w, end_last && (i == n - 1));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        armed = 1'b1;
        step(1, 0, 0, 0, 0);
        expect_out("R1", 0, 0, 0, 0);

        // R2, R9: native header with gaps
        cur_req = "R2";
        send_words(0, 21, -1, 0, 1, 0);
        expect_out("R2", 1, 1, 0, 0);
        // R7: trailing words and end marker ignored
        cur_req = "R7";
        step(1, 0, 1, 32'h12345678, 0);
        step(1, 0, 1, 32'h0, 1);
        step(1, 0, 0, 0, 0);
        expect_out("R7", 1, 1, 0, 0);

        // R3: byte-reversed header
        cur_req = "R3";
        step(1, 1, 0, 0, 0);
        expect_out("R8", 0, 0, 0, 0);
        send_words(1, 21, -1, 0, 0, 0);
        expect_out("R3", 1, 1, 1, 0);

        // R9: byte-reversed header with gaps
        cur_req = "R9";
        step(1, 1, 0, 0, 0);
        send_words(1, 21, -1, 0, 1, 0);
        expect_out("R9", 1, 1, 1, 0);

        // R4: native header, marker word corrupted
        cur_req = "R4";
        step(1, 1, 0, 0, 0);
        send_words(0, 21, 16, 32'h000000BA, 0, 0);
        expect_out("R4", 1, 0, 0, 0);
        // R4: reversed header with one native-order marker
        step(1, 1, 0, 0, 0);
        send_words(1, 21, 17, 32'h11220044, 0, 0);
        expect_out("R4", 1, 0, 1, 0);
        // R4: native words closed by a reversed sync word
        step(1, 1, 0, 0, 0);
        send_words(0, 21, 20, 32'h665599AA, 0, 0);
        expect_out("R4", 1, 0, 1, 0);

        // R5: unknown sync word
        cur_req = "R5";
        step(1, 1, 0, 0, 0);
        send_words(0, 21, 20, 32'h12345678, 0, 0);
        expect_out("R5", 1, 0, 0, 0);

        // R6: stream ends after 10 words, and immediately after start
        cur_req = "R6";
        step(1, 1, 0, 0, 0);
        send_words(0, 10, -1, 0, 0, 1);
        expect_out("R6", 1, 0, 0, 1);
        step(1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        expect_out("R6", 1, 0, 0, 1);
        // R6: end marker with sync word completes the header
        step(1, 1, 0, 0, 0);
        send_words(0, 21, -1, 0, 0, 1);
        expect_out("R6", 1, 1, 0, 0);

        // R8: word with start is discarded
        cur_req = "R8";
        step(1, 1, 1, 32'h000000BB, 0);
        send_words(0, 21, -1, 0, 0, 0);
        expect_out("R8", 1, 1, 0, 0);
        // R8: restart in the middle of a header
        step(1, 1, 0, 0, 0);
        send_words(1, 5, -1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        send_words(0, 21, -1, 0, 0, 0);
        expect_out("R8", 1, 1, 0, 0);

        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule